// File: doc/BRIEF.md
# Banked private register window router

This block sits in front of a 4 KB register window that several processors share. Each access carries the number of the processor that issues it, an address, a read or write strobe and write data. The block decodes the low twelve address bits and routes the access to one of three kinds of target. The first is a small snoop-control register set that the block keeps itself. The second is one of the per-processor interrupt CPU interfaces. The third is one of the per-processor timer instances, with one timer and one watchdog for each processor.

Two pages are aliased: they always reach the instance that belongs to the requesting processor. Further banked pages give direct access to any processor's instance. Selects are one-hot and combinational. The target sees a trimmed sub-offset, the write strobe and the write data. Read data comes back through a registered mux one cycle after the read strobe. An access to an illegal location raises a one-cycle error flag, returns zero and changes nothing. The block also routes each timer instance's interrupt line onto the right private interrupt number of its owning processor.

Top module: `privwin_router`

## Requirements
- R1: Only `req_addr[11:0]` is decoded. Address bits above bit 11 have no effect on routing, data or errors.
- R2: The control register sits at offset 0x000. A write stores only `req_wdata[0]`. A read returns that bit zero-extended, and `scu_enable` shows its value from the cycle after the write. It resets to 0.
- R3: Offset 0x004 reads 0x000000F3. Offsets 0x008 and 0x00C read 0. A write to 0x00C is accepted without error and changes nothing.
- R4: Offsets 0x100-0x1FF assert `gic_sel[req_cpu]`. `gic_offs` carries `req_addr[7:0]`.
- R5: Offsets 0x200-0x5FF assert `gic_sel[req_addr[11:8]-2]`.
- R6: Offsets 0x600-0x6FF select the timer pair of `req_cpu`, and 0x700-0xAFF select pair `req_addr[11:8]-7`. The selected bit is `tmr_sel[2*pair + req_addr[5]]`, where bit 5 set means watchdog, and `tmr_offs` carries `req_addr[3:0]`.
- R7: The following accesses are illegal: offsets 0xB00 and above, snoop-control offsets other than 0x000/0x004/0x008/0x00C, writes to 0x004 or 0x008, and an access with both strobes high. An illegal access asserts no select and changes no state. In the next cycle `rsp_err` is 1 and `rsp_rdata` is 0, and `rsp_err` is 0 after any legal or idle cycle.
- R8: `rsp_rdata` holds the chosen target's read data one cycle after a legal read. It is 0 in the cycle after any cycle without a read.
- R9: `priv_irq[32*c + 29]` follows `tmr_irq[2*c]` and `priv_irq[32*c + 30]` follows `tmr_irq[2*c+1]`. All other `priv_irq` bits are 0.
- R10: Selects are at most one-hot across `gic_sel` and `tmr_sel` and are all 0 without a strobe. `tgt_wr` is high only for a legal write, and `tgt_wdata` carries `req_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_cpu | input | $clog2(N_CPU) | Number of the requesting processor |
| req_addr | input | ADDR_W | Access address; low 12 bits decoded |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_wdata | input | DATA_W | Write data |
| gic_sel | output | N_CPU | One-hot select of interrupt CPU interfaces |
| gic_offs | output | 8 | Sub-offset for the interrupt interface |
| gic_rdata | input | N_CPU*DATA_W | Read data of each interrupt interface, index 0 lowest |
| tmr_sel | output | 2*N_CPU | One-hot select of timer instances |
| tmr_offs | output | 4 | Sub-offset for the timer instance |
| tmr_rdata | input | 2*N_CPU*DATA_W | Read data of each timer instance, index 0 lowest |
| tgt_wr | output | 1 | Write strobe forwarded to the selected target |
| tgt_wdata | output | DATA_W | Write data forwarded to targets |
| rsp_rdata | output | DATA_W | Registered read response |
| rsp_err | output | 1 | Registered illegal-access flag |
| scu_enable | output | 1 | Stored snoop-control enable bit |
| tmr_irq | input | 2*N_CPU | Interrupt line of each timer instance |
| priv_irq | output | 32*N_CPU | Private interrupt vector per processor |

## Verification
Because the response is registered, a new access is decoded in the same cycle that the previous read's data is being returned. The bench provokes this with strobes that follow each other with no idle cycle between them. One case reads the control register and writes it in the very next cycle; the response must still carry the old value while `scu_enable` takes the new one. Another case places an illegal access immediately before a legal read of 0x004; the error flag must last exactly one cycle and the following response must be 0xF3. Interrupt routing is judged in the same windows, since it is combinational and independent of the access path.

// File: rtl/privwin_pkg.sv
package privwin_pkg;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_SCU  = 2'd1,
      TGT_GIC  = 2'd2,
      TGT_TMR  = 2'd3
   } tgt_e;

   // snoop-control register offsets within page 0
   localparam logic [7:0] SCU_CTRL = 8'h00;
   localparam logic [7:0] SCU_CFG  = 8'h04;
   localparam logic [7:0] SCU_STAT = 8'h08;
   localparam logic [7:0] SCU_INV  = 8'h0C;

   localparam logic [7:0] SCU_CFG_VAL = 8'hF3;

   // private interrupt number of the first timer instance in a pair
   localparam int PPI_TIMER_BASE = 29;
   localparam int PPI_PER_CPU    = 32;

   localparam int WIN_BITS = 12;

endpackage

// File: rtl/privwin_addr_dec.sv
module privwin_addr_dec
   import privwin_pkg::*;
#(
   parameter int N_CPU = 4
) (
   input  logic [$clog2(N_CPU)-1:0] cpu,
   input  logic [11:0]              off,
   input  logic                     rd,
   input  logic                     wr,
   output tgt_e                     tgt,
   output logic [$clog2(N_CPU)-1:0] gic_idx,
   output logic [$clog2(N_CPU):0]   tmr_idx,
   output logic                     illegal
);

   localparam int CPU_W = $clog2(N_CPU);

   // page layout follows from the processor count
   localparam logic [3:0] PG_SCU      = 4'd0;
   localparam logic [3:0] PG_GIC_OWN  = 4'd1;
   localparam logic [3:0] PG_GIC_BANK = 4'd2;
   localparam logic [3:0] PG_TMR_OWN  = 4'(2 + N_CPU);
   localparam logic [3:0] PG_TMR_BANK = 4'(3 + N_CPU);
   localparam logic [3:0] PG_END      = 4'(3 + 2 * N_CPU);

   logic [3:0] page;
   logic       cpu_ok;

   assign page   = off[11:8];
   assign cpu_ok = (int'(cpu) < N_CPU);

   always_comb begin
      tgt     = TGT_NONE;
      gic_idx = '0;
      tmr_idx = '0;
      illegal = 1'b0;
      if (rd || wr) begin
         if (rd && wr) begin
            illegal = 1'b1;
         end else if (page == PG_SCU) begin
            tgt = TGT_SCU;
            case (off[7:0])
               SCU_CTRL, SCU_INV: ;
               SCU_CFG, SCU_STAT: illegal = wr;
               default:           illegal = 1'b1;
            endcase
         end else if (page == PG_GIC_OWN) begin
            tgt     = TGT_GIC;
            gic_idx = cpu;
            illegal = !cpu_ok;
         end else if (page < PG_TMR_OWN) begin
            tgt     = TGT_GIC;
            gic_idx = CPU_W'(page - PG_GIC_BANK);
         end else if (page == PG_TMR_OWN) begin
            tgt     = TGT_TMR;
            tmr_idx = {cpu, off[5]};
            illegal = !cpu_ok;
         end else if (page < PG_END) begin
            tgt     = TGT_TMR;
            tmr_idx = {CPU_W'(page - PG_TMR_BANK), off[5]};
         end else begin
            illegal = 1'b1;
         end
         if (illegal) begin
            tgt     = TGT_NONE;
            gic_idx = '0;
            tmr_idx = '0;
         end
      end
   end

endmodule

// File: rtl/privwin_snoop_regs.sv
module privwin_snoop_regs
   import privwin_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic              wr,
   input  logic [7:0]        reg_off,
   input  logic              wbit,
   output logic [DATA_W-1:0] rdata,
   output logic              enable
);

   logic ctrl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= 1'b0;
      end else if (hit && wr && (reg_off == SCU_CTRL)) begin
         ctrl_q <= wbit;
      end
   end

   always_comb begin
      case (reg_off)
         SCU_CTRL: rdata = DATA_W'(ctrl_q);
         SCU_CFG:  rdata = DATA_W'(SCU_CFG_VAL);
         default:  rdata = '0;
      endcase
   end

   assign enable = ctrl_q;

endmodule

// File: rtl/privwin_rdata_mux.sv
module privwin_rdata_mux
   import privwin_pkg::*;
#(
   parameter int N_CPU  = 4,
   parameter int DATA_W = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rd,
   input  logic                        illegal,
   input  tgt_e                        tgt,
   input  logic [$clog2(N_CPU)-1:0]    gic_idx,
   input  logic [$clog2(N_CPU):0]      tmr_idx,
   input  logic [DATA_W-1:0]           scu_rdata,
   input  logic [N_CPU*DATA_W-1:0]     gic_rdata,
   input  logic [2*N_CPU*DATA_W-1:0]   tmr_rdata,
   output logic [DATA_W-1:0]           rsp_rdata,
   output logic                        rsp_err
);

   logic [DATA_W-1:0] pick;

   always_comb begin
      case (tgt)
         TGT_SCU: pick = scu_rdata;
         TGT_GIC: pick = gic_rdata[int'(gic_idx) * DATA_W +: DATA_W];
         TGT_TMR: pick = tmr_rdata[int'(tmr_idx) * DATA_W +: DATA_W];
         default: pick = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_err   <= illegal;
         rsp_rdata <= (rd && !illegal) ? pick : '0;
      end
   end

endmodule

// File: rtl/privwin_router.sv
module privwin_router
   import privwin_pkg::*;
#(
   parameter int N_CPU  = 4,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [$clog2(N_CPU)-1:0]    req_cpu,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic                        req_rd,
   input  logic                        req_wr,
   input  logic [DATA_W-1:0]           req_wdata,
   output logic [N_CPU-1:0]            gic_sel,
   output logic [7:0]                  gic_offs,
   input  logic [N_CPU*DATA_W-1:0]     gic_rdata,
   output logic [2*N_CPU-1:0]          tmr_sel,
   output logic [3:0]                  tmr_offs,
   input  logic [2*N_CPU*DATA_W-1:0]   tmr_rdata,
   output logic                        tgt_wr,
   output logic [DATA_W-1:0]           tgt_wdata,
   output logic [DATA_W-1:0]           rsp_rdata,
   output logic                        rsp_err,
   output logic                        scu_enable,
   input  logic [2*N_CPU-1:0]          tmr_irq,
   output logic [PPI_PER_CPU*N_CPU-1:0] priv_irq
);

   localparam int CPU_W  = $clog2(N_CPU);
   localparam int TIDX_W = CPU_W + 1;
   localparam int N_TMR  = 2 * N_CPU;

   // elaboration-time parameter checks
   if (N_CPU < 2 || N_CPU > 6) begin : g_bad_ncpu
      $error("privwin_router: N_CPU must lie in 2..6 so the pages fit in 4 KB");
   end
   if (DATA_W < 8) begin : g_bad_dw
      $error("privwin_router: DATA_W must be at least 8");
   end
   if (ADDR_W < WIN_BITS) begin : g_bad_aw
      $error("privwin_router: ADDR_W must cover the 12-bit window");
   end

   logic [11:0]        win_off;
   tgt_e               tgt;
   logic [CPU_W-1:0]   gic_idx;
   logic [TIDX_W-1:0]  tmr_idx;
   logic               illegal;
   logic [DATA_W-1:0]  scu_rdata;

   assign win_off = req_addr[11:0];

   // upper address bits are deliberately not decoded
   if (ADDR_W > WIN_BITS) begin : g_addr_hi
      logic unused_addr_hi;
      assign unused_addr_hi = ^req_addr[ADDR_W-1:WIN_BITS];
   end

   privwin_addr_dec #(.N_CPU(N_CPU)) u_dec (
      .cpu     (req_cpu),
      .off     (win_off),
      .rd      (req_rd),
      .wr      (req_wr),
      .tgt     (tgt),
      .gic_idx (gic_idx),
      .tmr_idx (tmr_idx),
      .illegal (illegal)
   );

   privwin_snoop_regs #(.DATA_W(DATA_W)) u_scu (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (tgt == TGT_SCU),
      .wr      (req_wr),
      .reg_off (win_off[7:0]),
      .wbit    (req_wdata[0]),
      .rdata   (scu_rdata),
      .enable  (scu_enable)
   );

   privwin_rdata_mux #(.N_CPU(N_CPU), .DATA_W(DATA_W)) u_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd        (req_rd),
      .illegal   (illegal),
      .tgt       (tgt),
      .gic_idx   (gic_idx),
      .tmr_idx   (tmr_idx),
      .scu_rdata (scu_rdata),
      .gic_rdata (gic_rdata),
      .tmr_rdata (tmr_rdata),
      .rsp_rdata (rsp_rdata),
      .rsp_err   (rsp_err)
   );

   for (genvar i = 0; i < N_CPU; i++) begin : g_gic_sel
      assign gic_sel[i] = (tgt == TGT_GIC) && (gic_idx == CPU_W'(i));
   end

   for (genvar k = 0; k < N_TMR; k++) begin : g_tmr_sel
      assign tmr_sel[k] = (tgt == TGT_TMR) && (tmr_idx == TIDX_W'(k));
   end

   assign gic_offs  = win_off[7:0];
   assign tmr_offs  = win_off[3:0];
   assign tgt_wr    = req_wr && (tgt != TGT_NONE);
   assign tgt_wdata = req_wdata;

   // timer k drives interrupt PPI_TIMER_BASE + k%2 of processor k/2
   for (genvar c = 0; c < N_CPU; c++) begin : g_irq_cpu
      for (genvar b = 0; b < PPI_PER_CPU; b++) begin : g_irq_bit
         if (b == PPI_TIMER_BASE) begin : g_tmr
            assign priv_irq[c*PPI_PER_CPU + b] = tmr_irq[2*c];
         end else if (b == PPI_TIMER_BASE + 1) begin : g_wdg
            assign priv_irq[c*PPI_PER_CPU + b] = tmr_irq[2*c + 1];
         end else begin : g_zero
            assign priv_irq[c*PPI_PER_CPU + b] = 1'b0;
         end
      end
   end

endmodule

// File: rtl/privwin_router_chk.sv
module privwin_router_chk #(
   parameter int N_CPU  = 4,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    req_addr,
   input logic                 req_rd,
   input logic                 req_wr,
   input logic [N_CPU-1:0]     gic_sel,
   input logic [2*N_CPU-1:0]   tmr_sel,
   input logic [DATA_W-1:0]    rsp_rdata,
   input logic                 rsp_err,
   input logic                 scu_enable
);

   AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gic_sel, tmr_sel}));                                      // R10

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_rd || req_wr) |-> (gic_sel == '0 && tmr_sel == '0));           // R10

   AST_ERR_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_rd || req_wr) && gic_sel == '0 && tmr_sel == '0 && req_addr[11:8] != 4'h0
         |=> rsp_err);                                                     // R7

   AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_rdata == '0);                                        // R7

   AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !req_rd |=> rsp_rdata == '0);                                        // R8

   AST_SCU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_wr && !req_rd && req_addr[11:0] == 12'h000) |=> $stable(scu_enable)); // R2

endmodule

bind privwin_router privwin_router_chk #(
   .N_CPU  (N_CPU),
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/sim_privwin_router.sv
module sim_privwin_router;

   localparam int N_CPU  = 4;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 32;
   localparam int N_TMR  = 2 * N_CPU;

   logic                        clk = 1'b0;
   logic                        rst_n = 1'b0;
   logic [1:0]                  req_cpu = '0;
   logic [ADDR_W-1:0]           req_addr = '0;
   logic                        req_rd = 1'b0;
   logic                        req_wr = 1'b0;
   logic [DATA_W-1:0]           req_wdata = '0;
   logic [N_CPU-1:0]            gic_sel;
   logic [7:0]                  gic_offs;
   logic [N_CPU*DATA_W-1:0]     gic_rdata;
   logic [N_TMR-1:0]            tmr_sel;
   logic [3:0]                  tmr_offs;
   logic [N_TMR*DATA_W-1:0]     tmr_rdata;
   logic                        tgt_wr;
   logic [DATA_W-1:0]           tgt_wdata;
   logic [DATA_W-1:0]           rsp_rdata;
   logic                        rsp_err;
   logic                        scu_enable;
   logic [N_TMR-1:0]            tmr_irq = '0;
   logic [32*N_CPU-1:0]         priv_irq;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;  // 50 MHz

   // target stubs: read data encodes instance and sub-offset
   for (genvar i = 0; i < N_CPU; i++) begin : g_gic_stub
      assign gic_rdata[i*DATA_W +: DATA_W] = 32'h6100_0000 | (32'(i) << 8) | {24'h0, gic_offs};
   end
   for (genvar k = 0; k < N_TMR; k++) begin : g_tmr_stub
      assign tmr_rdata[k*DATA_W +: DATA_W] = 32'h7200_0000 | (32'(k) << 8) | {28'h0, tmr_offs};
   end

   privwin_router #(.N_CPU(N_CPU), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
      .clk, .rst_n, .req_cpu, .req_addr, .req_rd, .req_wr, .req_wdata,
      .gic_sel, .gic_offs, .gic_rdata, .tmr_sel, .tmr_offs, .tmr_rdata,
      .tgt_wr, .tgt_wdata, .rsp_rdata, .rsp_err, .scu_enable, .tmr_irq, .priv_irq
   );

   typedef struct packed {
      logic [3:0]  req;
      logic [1:0]  cpu;
      logic [31:0] addr;
      logic        rd;
      logic        wr;
      logic [31:0] wdata;
      logic [3:0]  gsel;
      logic [7:0]  tsel;
      logic [31:0] rdata;
      logic        err;
   } vec_t;

   localparam int NV = 28;
   localparam vec_t TBL [NV] = '{
      '{4'd2,  2'd0, 32'h0000_0000, 1'b1, 1'b0, 32'h0,         4'h0, 8'h00, 32'h0000_0000, 1'b0}, // R2 reset value
      '{4'd2,  2'd0, 32'h0000_0000, 1'b0, 1'b1, 32'hFFFF_FFFF, 4'h0, 8'h00, 32'h0000_0000, 1'b0}, // R2 write
      '{4'd1,  2'd1, 32'h1234_5000, 1'b1, 1'b0, 32'h0,         4'h0, 8'h00, 32'h0000_0001, 1'b0}, // R1 high bits ignored
      '{4'd3,  2'd2, 32'h0000_0004, 1'b1, 1'b0, 32'h0,         4'h0, 8'h00, 32'h0000_00F3, 1'b0}, // R3
      '{4'd3,  2'd3, 32'h0000_0008, 1'b1, 1'b0, 32'h0,         4'h0, 8'h00, 32'h0000_0000, 1'b0}, // R3
      '{4'd3,  2'd0, 32'h0000_000C, 1'b0, 1'b1, 32'h0,         4'h0, 8'h00, 32'h0000_0000, 1'b0}, // R3 write ignored
      '{4'd3,  2'd0, 32'h0000_000C, 1'b1, 1'b0, 32'h0,         4'h0, 8'h00, 32'h0000_0000, 1'b0}, // R3
      '{4'd3,  2'd0, 32'h0000_0000, 1'b1, 1'b0, 32'h0,         4'h0, 8'h00, 32'h0000_0001, 1'b0}, // R3 ctrl kept
      '{4'd4,  2'd2, 32'h0000_01A4, 1'b1, 1'b0, 32'h0,         4'h4, 8'h00, 32'h6100_02A4, 1'b0}, // R4 own
      '{4'd10, 2'd3, 32'h0000_01FC, 1'b0, 1'b1, 32'hABCD_0123, 4'h8, 8'h00, 32'h0000_0000, 1'b0}, // R10 write
      '{4'd5,  2'd0, 32'h0000_0310, 1'b1, 1'b0, 32'h0,         4'h2, 8'h00, 32'h6100_0110, 1'b0}, // R5
      '{4'd5,  2'd1, 32'h0000_05FF, 1'b1, 1'b0, 32'h0,         4'h8, 8'h00, 32'h6100_03FF, 1'b0}, // R5 top
      '{4'd5,  2'd3, 32'h0000_0200, 1'b1, 1'b0, 32'h0,         4'h1, 8'h00, 32'h6100_0000, 1'b0}, // R5 base
      '{4'd6,  2'd1, 32'h0000_0608, 1'b1, 1'b0, 32'h0,         4'h0, 8'h04, 32'h7200_0208, 1'b0}, // R6 own timer
      '{4'd6,  2'd3, 32'h0000_062C, 1'b1, 1'b0, 32'h0,         4'h0, 8'h80, 32'h7200_070C, 1'b0}, // R6 own watchdog
      '{4'd6,  2'd0, 32'h0000_0700, 1'b1, 1'b0, 32'h0,         4'h0, 8'h01, 32'h7200_0000, 1'b0}, // R6 banked
      '{4'd6,  2'd2, 32'h0000_0A24, 1'b0, 1'b1, 32'h5A5A_5A5A, 4'h0, 8'h80, 32'h0000_0000, 1'b0}, // R6 banked wdog
      '{4'd6,  2'd0, 32'h0000_0934, 1'b1, 1'b0, 32'h0,         4'h0, 8'h20, 32'h7200_0504, 1'b0}, // R6
      '{4'd7,  2'd0, 32'h0000_0B00, 1'b1, 1'b0, 32'h0,         4'h0, 8'h00, 32'h0000_0000, 1'b1}, // R7 first bad page
      '{4'd7,  2'd1, 32'hFFFF_FFFC, 1'b0, 1'b1, 32'h1,         4'h0, 8'h00, 32'h0000_0000, 1'b1}, // R7
      '{4'd7,  2'd0, 32'h0000_0010, 1'b1, 1'b0, 32'h0,         4'h0, 8'h00, 32'h0000_0000, 1'b1}, // R7 unlisted
      '{4'd7,  2'd0, 32'h0000_0001, 1'b1, 1'b0, 32'h0,         4'h0, 8'h00, 32'h0000_0000, 1'b1}, // R7 unaligned
      '{4'd7,  2'd0, 32'h0000_0004, 1'b0, 1'b1, 32'h0,         4'h0, 8'h00, 32'h0000_0000, 1'b1}, // R7 ro write
      '{4'd7,  2'd0, 32'h0000_0000, 1'b1, 1'b1, 32'h0,         4'h0, 8'h00, 32'h0000_0000, 1'b1}, // R7 both strobes
      '{4'd7,  2'd0, 32'h0000_0000, 1'b1, 1'b0, 32'h0,         4'h0, 8'h00, 32'h0000_0001, 1'b0}, // R7 no state change
      '{4'd2,  2'd0, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0002, 4'h0, 8'h00, 32'h0000_0000, 1'b0}, // R2 bit1 dropped
      '{4'd2,  2'd0, 32'h0000_0000, 1'b1, 1'b0, 32'h0,         4'h0, 8'h00, 32'h0000_0000, 1'b0}, // R2
      '{4'd8,  2'd1, 32'h0000_0604, 1'b0, 1'b0, 32'h0,         4'h0, 8'h00, 32'h0000_0000, 1'b0}  // R8 idle
   };

   task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // drives at a falling edge, checks selects, then registered outputs at the next falling edge
   task automatic access(input vec_t v);
      string tag;
      tag = $sformatf("R%0d", v.req);
      req_cpu   = v.cpu;
      req_addr  = v.addr;
      req_rd    = v.rd;
      req_wr    = v.wr;
      req_wdata = v.wdata;
      #2;
      check(gic_sel == v.gsel, {tag, " gic_sel"}, 128'(gic_sel), 128'(v.gsel));
      check(tmr_sel == v.tsel, {tag, " tmr_sel"}, 128'(tmr_sel), 128'(v.tsel));
      if (v.gsel != '0)
         check(gic_offs == v.addr[7:0], {tag, " gic_offs"}, 128'(gic_offs), 128'(v.addr[7:0]));
      if (v.tsel != '0)
         check(tmr_offs == v.addr[3:0], {tag, " tmr_offs"}, 128'(tmr_offs), 128'(v.addr[3:0]));
      // R10 write strobe only for a legal write
      check(tgt_wr == (v.wr && !v.err), "R10 tgt_wr", 128'(tgt_wr), 128'(v.wr && !v.err));
      if (v.wr && !v.err)
         check(tgt_wdata == v.wdata, "R10 tgt_wdata", 128'(tgt_wdata), 128'(v.wdata));
      @(negedge clk);
      check(rsp_rdata == v.rdata, {tag, " rsp_rdata"}, 128'(rsp_rdata), 128'(v.rdata));
      check(rsp_err == v.err, {tag, " rsp_err"}, 128'(rsp_err), 128'(v.err));
   endtask

   task automatic idle();
      req_rd = 1'b0;
      req_wr = 1'b0;
      @(negedge clk);
   endtask

   function automatic vec_t mk(input logic [3:0] r, input logic [31:0] a, input logic rd,
                               input logic wr, input logic [31:0] wd,
                               input logic [31:0] rdat, input logic er);
      vec_t v;
      v = '{r, 2'd0, a, rd, wr, wd, 4'h0, 8'h00, rdat, er};
      return v;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : stim
      logic [127:0] exp_irq;
      // reset state
      repeat (3) @(negedge clk);
      check(rsp_rdata == '0, "R8 reset rdata", 128'(rsp_rdata), 128'(0));
      check(rsp_err == 1'b0, "R7 reset err", 128'(rsp_err), 128'(0));
      check(scu_enable == 1'b0, "R2 reset enable", 128'(scu_enable), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         access(TBL[i]);
         if (i == 1)
            check(scu_enable == 1'b1, "R2 enable after write", 128'(scu_enable), 128'(1));
         idle();
      end
      check(scu_enable == 1'b0, "R2 enable cleared", 128'(scu_enable), 128'(0));

      // back-to-back: read control, then write it the very next cycle
      access(mk(4'd2, 32'h0, 1'b0, 1'b1, 32'h1, 32'h0, 1'b0));
      access(mk(4'd8, 32'h0, 1'b1, 1'b0, 32'h0, 32'h1, 1'b0));
      access(mk(4'd8, 32'h0, 1'b0, 1'b1, 32'h0, 32'h0, 1'b0));
      check(scu_enable == 1'b0, "R2 back-to-back write", 128'(scu_enable), 128'(0));
      access(mk(4'd8, 32'h0, 1'b1, 1'b0, 32'h0, 32'h0, 1'b0));

      // back-to-back: illegal access directly followed by a legal read
      access(mk(4'd7, 32'h0000_0C00, 1'b1, 1'b0, 32'h0, 32'h0, 1'b1));
      access(mk(4'd7, 32'h0000_0004, 1'b1, 1'b0, 32'h0, 32'hF3, 1'b0));
      idle();
      check(rsp_rdata == '0 && rsp_err == 1'b0, "R8 idle after read", 128'({rsp_err, rsp_rdata}), 128'(0));

      // timer interrupt routing, R9
      for (int k = 0; k < N_TMR; k++) begin
         tmr_irq = N_TMR'(1) << k;
         #2;
         exp_irq = '0;
         exp_irq[(k / 2) * 32 + 29 + (k % 2)] = 1'b1;
         check(priv_irq == exp_irq, "R9 irq route", priv_irq, exp_irq);
         @(negedge clk);
      end
      tmr_irq = '1;
      #2;
      exp_irq = '0;
      for (int c = 0; c < N_CPU; c++) begin
         exp_irq[c * 32 + 29] = 1'b1;
         exp_irq[c * 32 + 30] = 1'b1;
      end
      check(priv_irq == exp_irq, "R9 irq all", priv_irq, exp_irq);
      tmr_irq = '0;
      @(negedge clk);

      // reset clears the control bit again
      access(mk(4'd2, 32'h0, 1'b0, 1'b1, 32'h1, 32'h0, 1'b0));
      rst_n = 1'b0;
      @(negedge clk);
      req_wr = 1'b0;
      @(negedge clk);
      check(scu_enable == 1'b0, "R2 reset clears", 128'(scu_enable), 128'(1'b0));
      rst_n = 1'b1;
      @(negedge clk);

      finish_run();
   end

endmodule